// File: doc/BRIEF.md
# Legacy System Control Port Block

This block is a byte-wide register file that sits on a simple synchronous I/O bus of a single-processor board. It answers a small set of 16-bit port addresses. Some ports are live control bits that drive board-level outputs: a soft reset request, the little-endian mode flag, the I/O map mode and a status light. Some are fixed identification and feature bytes. The rest are write-only ports whose only effect is a side effect.

Two of the write-only ports emit single-cycle lock-toggle pulses towards an external non-volatile memory. A 4-bit system control value is held for software to read back. Any read of a port that is not decoded returns all ones. Any access to an undecoded port raises a one-cycle error strobe, so that a test can see it.

Reads are registered, so read data appears one clock after the read strobe. Writes update the stored state and the outputs on the clock edge that samples the write strobe.

Top module: `sysport_ctl`

## Requirements
- R1: A write to port 0x0092 sets `reset_req` to data bit 0 and `le_mode` to data bit 1. Both take effect at the clock edge that samples the write, and both hold as levels until the next write to that port.
- R2: A read of port 0x0092 returns `{6'b0, le_mode, 1'b0}`.
- R3: Reads of ports 0x0800, 0x0802 and 0x0803 return 0xEF, 0xAD and 0xE0. A write to any of these three ports changes no output and no stored value, and raises no error.
- R4: Reads of ports 0x080C, 0x0810, 0x0818 and 0x0823 return 0x3C, 0x39, 0x00 and 0x03.
- R5: A write to port 0x0808 sets `light_on` to data bit 0.
- R6: A write to port 0x0810 makes `lock_pulse[0]` high for exactly one cycle. A write to port 0x0812 does the same on `lock_pulse[1]`. At most one bit of `lock_pulse` is high in any cycle.
- R7: A write to port 0x081C stores data bits 3:0. A read of port 0x081C returns `{4'b0, stored}`. No other write changes the stored value.
- R8: A write to port 0x0850 sets `map_mode` to data bit 0. A read of port 0x0850 returns `{7'b0, map_mode}`.
- R9: A read of any port not listed in R2, R3, R4, R7 or R8 returns 0xFF; port 0x0814 is one of these. A write to port 0x0814 is accepted and has no effect.
- R10: `access_err` is high for exactly the cycle after an access to an undecoded port. Undecoded reads are those in R9. Undecoded writes are writes to any port other than 0x0092, 0x0800, 0x0802, 0x0803, 0x0808, 0x0810, 0x0812, 0x0814, 0x081C and 0x0850.
- R11: After reset, every output is zero, `rdata` is 0x00 and the stored control value is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 16 | Port address |
| wdata | input | 8 | Write data |
| wr_en | input | 1 | Write strobe, one access per cycle high |
| rd_en | input | 1 | Read strobe, one access per cycle high |
| rdata | output | 8 | Read data, registered, valid the cycle after `rd_en` |
| reset_req | output | 1 | Soft reset request level |
| le_mode | output | 1 | Little-endian mode flag |
| map_mode | output | 1 | I/O map mode bit |
| light_on | output | 1 | Status light |
| lock_pulse | output | 2 | Lock-toggle pulses; bit 0 is index 1, bit 1 is index 2 |
| access_err | output | 1 | One-cycle strobe for an access to an undecoded port |

## Verification
Every result of this block is due one clock after the access that causes it:
- the control levels,
- the lock pulses,
- the error strobe,
- the registered read data.

The bench drives each access on a falling edge. It lets exactly one rising edge pass and samples on the next falling edge, which is the cycle the result is due. For the one-cycle strobes, the bench samples once more a cycle later to confirm they have dropped. Writes to read-only and side-effect-free ports are followed by reads and output checks, so that an unintended change is visible at the ports.

// File: rtl/sysport_ctl.sv
module sysport_ctl #(
  parameter int AW = 16,
  parameter int DW = 8,
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic          wr_en,
  input  logic          rd_en,
  output logic [DW-1:0] rdata,
  output logic          reset_req,
  output logic          le_mode,
  output logic          map_mode,
  output logic          light_on,
  output logic [1:0]    lock_pulse,
  output logic          access_err
);

  localparam logic [AW-1:0] P_SPECIAL = AW'(16'h0092);
  localparam logic [AW-1:0] P_CPUCFG  = AW'(16'h0800);
  localparam logic [AW-1:0] P_FEAT    = AW'(16'h0802);
  localparam logic [AW-1:0] P_MODSTAT = AW'(16'h0803);
  localparam logic [AW-1:0] P_LIGHT   = AW'(16'h0808);
  localparam logic [AW-1:0] P_EQUIP   = AW'(16'h080C);
  localparam logic [AW-1:0] P_LOCK1   = AW'(16'h0810);
  localparam logic [AW-1:0] P_LOCK2   = AW'(16'h0812);
  localparam logic [AW-1:0] P_INVAL   = AW'(16'h0814);
  localparam logic [AW-1:0] P_KEY     = AW'(16'h0818);
  localparam logic [AW-1:0] P_CTRL    = AW'(16'h081C);
  localparam logic [AW-1:0] P_CACHE   = AW'(16'h0823);
  localparam logic [AW-1:0] P_MAP     = AW'(16'h0850);

  localparam logic [DW-1:0] ALL_ONES = '1;

  logic [CW-1:0] ctrl_q;
  logic [DW-1:0] rd_val;
  logic          rd_hit;
  logic          wr_hit;

  always_comb begin
    rd_hit = 1'b1;
    rd_val = ALL_ONES;
    unique case (addr)
      P_SPECIAL: rd_val = DW'({le_mode, 1'b0});
      P_CPUCFG:  rd_val = DW'(8'hEF);
      P_FEAT:    rd_val = DW'(8'hAD);
      P_MODSTAT: rd_val = DW'(8'hE0);
      P_EQUIP:   rd_val = DW'(8'h3C);
      P_LOCK1:   rd_val = DW'(8'h39);
      P_KEY:     rd_val = DW'(8'h00);
      P_CTRL:    rd_val = DW'(ctrl_q);
      P_CACHE:   rd_val = DW'(8'h03);
      P_MAP:     rd_val = DW'(map_mode);
      default:   rd_hit = 1'b0;
    endcase
  end

  always_comb begin
    unique case (addr)
      P_SPECIAL, P_CPUCFG, P_FEAT, P_MODSTAT, P_LIGHT,
      P_LOCK1, P_LOCK2, P_INVAL, P_CTRL, P_MAP: wr_hit = 1'b1;
      default: wr_hit = 1'b0;
    endcase
  end

  wire wr_special = wr_en && addr == P_SPECIAL;
  wire wr_light   = wr_en && addr == P_LIGHT;
  wire wr_ctrl    = wr_en && addr == P_CTRL;
  wire wr_map     = wr_en && addr == P_MAP;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reset_req  <= 1'b0;
      le_mode    <= 1'b0;
      map_mode   <= 1'b0;
      light_on   <= 1'b0;
      ctrl_q     <= '0;
      lock_pulse <= '0;
      access_err <= 1'b0;
      rdata      <= '0;
    end else begin
      if (wr_special) begin
        reset_req <= wdata[0];
        le_mode   <= wdata[1];
      end
      if (wr_light) light_on <= wdata[0];
      if (wr_ctrl)  ctrl_q   <= wdata[CW-1:0];
      if (wr_map)   map_mode <= wdata[0];
      lock_pulse <= {wr_en && addr == P_LOCK2, wr_en && addr == P_LOCK1};
      access_err <= (rd_en && !rd_hit) || (wr_en && !wr_hit);
      if (rd_en) rdata <= rd_val;
    end
  end

  // R1
  special_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_special |=> (reset_req == $past(wdata[0]) && le_mode == $past(wdata[1])));

  // R1
  special_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_special |=> ($stable(reset_req) && $stable(le_mode)));

  // R6
  lock_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lock_pulse));

  // R6
  lock_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock_pulse[0] |=> !lock_pulse[0] || $past(wr_en && addr == P_LOCK1));

  // R7
  ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ctrl |=> $stable(ctrl_q));

  // R3
  readonly_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (addr == P_CPUCFG || addr == P_FEAT || addr == P_MODSTAT)) |=>
      ($stable({reset_req, le_mode, map_mode, light_on, ctrl_q}) && !access_err));

  // R8
  map_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_map |=> $stable(map_mode));

endmodule

// File: tb/sysport_ctl_tb.sv
module sysport_ctl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [7:0]  rdata;
  logic        reset_req, le_mode, map_mode, light_on, access_err;
  logic [1:0]  lock_pulse;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  sysport_ctl u_dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wr_en(wr_en),
    .rd_en(rd_en), .rdata(rdata), .reset_req(reset_req), .le_mode(le_mode),
    .map_mode(map_mode), .light_on(light_on), .lock_pulse(lock_pulse),
    .access_err(access_err)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  function automatic logic [7:0] outs();
    return {3'b0, access_err, light_on, map_mode, le_mode, reset_req};
  endfunction

  task automatic t_reset();
    check("R11 outputs", outs(), 8'h00);
    check("R11 lock", {6'b0, lock_pulse}, 8'h00);
    check("R11 rdata", rdata, 8'h00);
    rd(16'h081C);
    check("R11 ctrl", rdata, 8'h00);
  endtask

  task automatic t_special();
    wr(16'h0092, 8'h03);
    check("R1 rr/le set", {6'b0, le_mode, reset_req}, 8'h03);
    rd(16'h0092);
    check("R2 read le=1", rdata, 8'h02);
    wr(16'h0092, 8'h00);
    check("R1 cleared", {6'b0, le_mode, reset_req}, 8'h00);
    rd(16'h0092);
    check("R2 read le=0", rdata, 8'h00);
    wr(16'h0092, 8'hFE);
    check("R1 le only", {6'b0, le_mode, reset_req}, 8'h02);
    repeat (3) @(negedge clk);
    check("R1 level held", {6'b0, le_mode, reset_req}, 8'h02);
    wr(16'h0092, 8'h01);
    check("R1 rr only", {6'b0, le_mode, reset_req}, 8'h01);
    rd(16'h0092);
    check("R2 read rr only", rdata, 8'h00);
    wr(16'h0092, 8'h00);
  endtask

  task automatic t_ids();
    rd(16'h0800); check("R3 0800", rdata, 8'hEF);
    rd(16'h0802); check("R3 0802", rdata, 8'hAD);
    rd(16'h0803); check("R3 0803", rdata, 8'hE0);
    wr(16'h0808, 8'h01);
    wr(16'h081C, 8'h06);
    wr(16'h0800, 8'h00);
    check("R3 ro write no err", {7'b0, access_err}, 8'h00);
    wr(16'h0802, 8'hFF);
    wr(16'h0803, 8'h00);
    check("R3 ro outputs kept", outs(), 8'h08);
    rd(16'h0800); check("R3 0800 after write", rdata, 8'hEF);
    rd(16'h081C); check("R3 ctrl kept", rdata, 8'h06);
    rd(16'h080C); check("R4 080C", rdata, 8'h3C);
    rd(16'h0810); check("R4 0810", rdata, 8'h39);
    rd(16'h0818); check("R4 0818", rdata, 8'h00);
    rd(16'h0823); check("R4 0823", rdata, 8'h03);
  endtask

  task automatic t_light();
    wr(16'h0808, 8'hFE);
    check("R5 light off", {7'b0, light_on}, 8'h00);
    wr(16'h0808, 8'h81);
    check("R5 light on", {7'b0, light_on}, 8'h01);
    wr(16'h0808, 8'h00);
    check("R5 light off again", {7'b0, light_on}, 8'h00);
  endtask

  task automatic t_lock();
    wr(16'h0810, 8'h00);
    check("R6 pulse 1", {6'b0, lock_pulse}, 8'h01);
    @(negedge clk);
    check("R6 pulse 1 ends", {6'b0, lock_pulse}, 8'h00);
    wr(16'h0812, 8'h55);
    check("R6 pulse 2", {6'b0, lock_pulse}, 8'h02);
    check("R6 no err", {7'b0, access_err}, 8'h00);
    @(negedge clk);
    check("R6 pulse 2 ends", {6'b0, lock_pulse}, 8'h00);
    rd(16'h0810);
    check("R6 read no pulse", {6'b0, lock_pulse}, 8'h00);
  endtask

  task automatic t_ctrl();
    wr(16'h081C, 8'hA5);
    rd(16'h081C); check("R7 low nibble", rdata, 8'h05);
    wr(16'h081C, 8'hFF);
    rd(16'h081C); check("R7 all ones", rdata, 8'h0F);
    wr(16'h0850, 8'h00);
    rd(16'h081C); check("R7 kept by other write", rdata, 8'h0F);
  endtask

  task automatic t_map();
    wr(16'h0850, 8'h03);
    check("R8 map set", {7'b0, map_mode}, 8'h01);
    rd(16'h0850); check("R8 read 1", rdata, 8'h01);
    wr(16'h0850, 8'h02);
    check("R8 map clear", {7'b0, map_mode}, 8'h00);
    rd(16'h0850); check("R8 read 0", rdata, 8'h00);
  endtask

  task automatic t_undecoded();
    rd(16'h0814);
    check("R9 0814 read", rdata, 8'hFF);
    check("R10 0814 read err", {7'b0, access_err}, 8'h01);
    @(negedge clk);
    check("R10 err one cycle", {7'b0, access_err}, 8'h00);
    rd(16'h1234);
    check("R9 far port", rdata, 8'hFF);
    check("R10 far read err", {7'b0, access_err}, 8'h01);
    rd(16'h0808);
    check("R9 0808 read", rdata, 8'hFF);
    wr(16'h0092, 8'h02);
    wr(16'h0808, 8'h01);
    wr(16'h0850, 8'h01);
    wr(16'h0814, 8'hFF);
    check("R9 0814 write no effect", outs(), 8'h0E);
    rd(16'h081C); check("R9 ctrl after 0814", rdata, 8'h0F);
    wr(16'h0900, 8'h01);
    check("R10 undecoded write err", outs(), 8'h1E);
    @(negedge clk);
    check("R10 err cleared", outs(), 8'h0E);
    wr(16'h0818, 8'h01);
    check("R10 write to read-only id err", {7'b0, access_err}, 8'h01);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_special();
    t_ids();
    t_light();
    t_lock();
    t_ctrl();
    t_map();
    t_undecoded();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule